// File: doc/BRIEF.md
# Interrupt Request Capture with Per-Line Trigger Mode

This block turns a set of asynchronous interrupt lines into a registered request vector. Each line first passes through a two-flop synchroniser. The block then treats the line as level-sensitive or edge-sensitive, according to its bit in a trigger-mode register.

A level-sensitive request follows the synchronised input. An edge-sensitive request is set by a low-to-high transition and holds until an acknowledge strobe names that line. Rising edges are found by comparing against a stored copy of each line's previous synchronised level. That copy is updated every cycle, whatever the line's mode.

The trigger-mode register is written and read through a byte-wide configuration port. Only the bits enabled by a fixed writable mask can be set. Downstream priority and in-service logic consume the request vector.

Top module: `irq_req_capture`

## Requirements
- R1: After reset, `req_o` is all zero and `cfg_rdata_o` reads zero, so every line is edge-sensitive.
- R2: A change on `irq_i` passes two synchroniser flops. It reaches `req_o` at the third rising clock edge after it is applied, and not before.
- R3: For a line whose mode bit is 1 (level), the request bit is 1 while the synchronised input is high and 0 while it is low.
- R4: For a line whose mode bit is 0 (edge), the request bit is set when the synchronised input is high and the stored previous level is low.
- R5: For an edge line, a falling input leaves the request bit set. Only the stored previous level falls.
- R6: When `ack_valid_i` is high, the edge request of the line whose index is `ack_line_i` clears at the next clock edge. Other lines are unaffected.
- R7: An acknowledge naming a level line has no effect on that line's request bit.
- R8: If an edge line sees a new rising edge in the same cycle as its acknowledge, the request stays set.
- R9: When `cfg_we_i` is high, the mode register takes `cfg_wdata_i & WR_MASK` at the next clock edge, and `cfg_rdata_o` returns the stored value. Bit i selects the mode of line i.
- R10: Mode bits outside `WR_MASK` always read 0, and their lines stay edge-sensitive whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_LINES | Asynchronous interrupt lines |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | N_LINES | Mode register write data (1 = level, 0 = edge) |
| cfg_rdata_o | output | N_LINES | Mode register contents |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_line_i | input | LINE_W | Index of the acknowledged line |
| req_o | output | N_LINES | Request vector |

## Verification
The bench builds the block with eight lines and a writable mask of 8'hF7, so line 3 can never become level-sensitive. This brings R10 within reach: a write of all ones still leaves line 3 latching edges, and it is still cleared by acknowledge. The remaining lines reach every mix of edge and level modes under random writes.

Random line toggles, acknowledges and mode changes are compared every cycle against a cycle-accurate model in the bench. Directed sequences then exercise the three-edge latency, acknowledge on level lines, and a rising edge that coincides with its acknowledge.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int unsigned N_LINES_DEF = 8;
  localparam int unsigned SYNC_STAGES = 2;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  assert_sync_stage1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> s1_q == $past(d_i));
  assert_sync_stage2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == $past(s1_q));
endmodule

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int unsigned      WIDTH   = 8,
  parameter logic [WIDTH-1:0] WR_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] trig_o
);
  logic [WIDTH-1:0] trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   trig_q <= '0;
    else if (we_i) trig_q <= wdata_i & WR_MASK;
  end

  assign trig_o = trig_q;

  assert_trig_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> trig_o == ($past(wdata_i) & WR_MASK));
  assert_trig_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(trig_o));
  assert_trig_fixed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (trig_o & ~WR_MASK) == '0);
endmodule

// File: rtl/irq_req_line.sv
module irq_req_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic trig_i,
  input  logic ack_i,
  output logic req_o
);
  import irq_cap_pkg::*;

  logic last_q, req_q, rise;

  assign rise = lvl_i & ~last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      last_q <= lvl_i;
      if (trig_i == TRIG_LEVEL) req_q <= lvl_i;
      else if (rise)            req_q <= 1'b1; // new edge beats ack
      else if (ack_i)           req_q <= 1'b0;
    end
  end

  assign req_o = req_q;

  assert_level_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && lvl_i) |=> req_o);
  assert_level_low_R3_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !lvl_i) |=> !req_o);
  assert_edge_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && lvl_i && !last_q) |=> req_o);
  assert_edge_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && req_o && !ack_i) |=> req_o);
  assert_edge_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && ack_i && !(lvl_i && !last_q)) |=> !req_o);
  assert_edge_ack_tie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && ack_i && lvl_i && !last_q) |=> req_o);
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int unsigned        N_LINES = irq_cap_pkg::N_LINES_DEF,
  parameter logic [N_LINES-1:0] WR_MASK = '1,
  localparam int unsigned       LINE_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               cfg_we_i,
  input  logic [N_LINES-1:0] cfg_wdata_i,
  output logic [N_LINES-1:0] cfg_rdata_o,
  input  logic               ack_valid_i,
  input  logic [LINE_W-1:0]  ack_line_i,
  output logic [N_LINES-1:0] req_o
);
  logic [N_LINES-1:0] lvl, trig, ack_oh;

  irq_sync #(.WIDTH(N_LINES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(lvl)
  );

  irq_trig_reg #(.WIDTH(N_LINES), .WR_MASK(WR_MASK)) u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .trig_o(trig)
  );

  assign cfg_rdata_o = trig;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign ack_oh[i] = ack_valid_i && (ack_line_i == LINE_W'(i));
    irq_req_line u_line (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl[i]), .trig_i(trig[i]),
      .ack_i(ack_oh[i]), .req_o(req_o[i])
    );
  end

  assert_ack_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_oh));
  assert_ack_other_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_valid_i && (trig == '0) && (lvl == '0)) |=> $stable(req_o));
endmodule

// File: tb/irq_req_capture_tb.sv
module irq_req_capture_tb;
  localparam int unsigned N = 8;
  localparam logic [N-1:0] MASK = 8'hF7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq = '0, wdata = '0, rdata, req;
  logic we = 1'b0, ack_v = 1'b0;
  logic [2:0] ack_l = '0;
  int checks = 0, errors = 0;
  logic [N-1:0] m_s1, m_s2, m_last, m_req, m_trig;

  always #2.5 clk = ~clk;

  irq_req_capture #(.N_LINES(N), .WR_MASK(MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .ack_valid_i(ack_v),
    .ack_line_i(ack_l), .req_o(req)
  );

  // next request bit from R3..R8
  function automatic logic next_req(logic trig, logic s2, logic last, logic cur, logic ack);
    if (trig) return s2;
    if (s2 && !last) return 1'b1;
    if (ack) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_last <= '0; m_req <= '0; m_trig <= '0;
    end else begin
      m_s1 <= irq; m_s2 <= m_s1; m_last <= m_s2;
      if (we) m_trig <= wdata & MASK;
      for (int i = 0; i < N; i++)
        m_req[i] <= next_req(m_trig[i], m_s2[i], m_last[i], m_req[i],
                             ack_v && (ack_l == 3'(i)));
    end
  end

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic cmp(string tag);
    check({tag, " req"}, req, m_req);
    check({tag, " mode"}, rdata, m_trig);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req reset", req, '0);
    check("R1 mode reset", rdata, '0);
    rst_n = 1'b1;
    step(1);

    // R2 latency: edge line 0
    irq = 8'h01; step(2);
    check("R2 not yet", req, '0);
    step(1);
    check("R2 third edge R4", req, 8'h01);
    // R5 fall keeps edge request
    irq = 8'h00; step(4);
    check("R5 fall holds", req, 8'h01);
    // R6 ack clears only named line
    irq = 8'h02; step(3);
    ack_v = 1'b1; ack_l = 3'd0; step(1); ack_v = 1'b0;
    check("R6 ack line0", req, 8'h02);

    // R9/R10 write all ones
    we = 1'b1; wdata = 8'hFF; step(1); we = 1'b0;
    check("R9 R10 mode readback", rdata, 8'hF7);
    irq = 8'h00; step(3);
    check("R3 level follows low", req, 8'h00);
    irq = 8'h30; step(3);
    check("R3 level follows high", req, 8'h30);
    ack_v = 1'b1; ack_l = 3'd4; step(1); ack_v = 1'b0;
    check("R7 ack level ignored", req, 8'h30);
    // line 3 stays edge
    irq = 8'h38; step(3); irq = 8'h30; step(3);
    check("R10 line3 latches", req, 8'h38);
    ack_v = 1'b1; ack_l = 3'd3; step(1); ack_v = 1'b0;
    check("R10 line3 acked", req, 8'h30);

    // R8 tie: line 3 rises again, ack same cycle as edge reaches logic
    irq = 8'h38; step(2);
    ack_v = 1'b1; ack_l = 3'd3; step(1); ack_v = 1'b0;
    check("R8 edge beats ack", req, 8'h38);
    step(1);
    cmp("R8 model");

    // random phase vs model
    for (int c = 0; c < 3000; c++) begin
      for (int b = 0; b < N; b++) if (($urandom % 8) == 0) irq[b] = ~irq[b];
      ack_v = (($urandom % 3) == 0);
      ack_l = 3'($urandom);
      we = (($urandom % 40) == 0);
      wdata = 8'($urandom);
      step(1);
      cmp("R3 R4 R5 R6 R7 R8 R9 random");
    end
    we = 1'b0; ack_v = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule